// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Protocol Engine

This block is the byte-level protocol engine of a serial EEPROM slave that sits on a two-wire bus. It takes already-detected bus events as one-cycle strobes: bus START (first or repeated), bus STOP, SCL rising, SCL falling. It also takes the current level of the data line. It produces a single open-drain pull-down request for that line. A three-bit strap input sets which of eight device slots the engine answers to. A write-protect input blocks changes to the array. The storage array is a synchronous RAM model inside the block.

A transaction opens with a device-select byte. Bits 7..4 are the control code 1010, bits 3..1 must equal the straps, and bit 0 is the direction (0 write, 1 read). For a write, a high address byte and a low address byte follow. Only the low 5 bits of the high byte are used, giving a 13-bit word address (0x0000..0x1FFF). Data bytes then fill a 32-entry page latch. A STOP then starts a self-timed programming interval of `PROG_CYCLES` clocks, which copies the latched bytes into their page. The device acknowledges no device-select byte until that interval ends. Reads send the byte at the current address, MSB first, and advance the address after every byte sent. A random read is a write of the address only, followed by a repeated START with a read select.

The controller states are:
- `ST_IDLE`: ignores clocks until a START.
- `ST_DEVSEL`: shifts in the select byte; goes to `ST_ACK_DEV` after 8 bits.
- `ST_ACK_DEV`: acknowledges or not. On a refusal it returns to `ST_IDLE`. After the acknowledge slot it goes to `ST_RD_DATA` for a read, or to `ST_ADDR_HI` for a write.
- `ST_ADDR_HI`: shifts in the high address byte, then goes to `ST_ACK_HI`.
- `ST_ACK_HI`: acknowledges, then goes to `ST_ADDR_LO`.
- `ST_ADDR_LO`: shifts in the low address byte, then goes to `ST_ACK_LO`.
- `ST_ACK_LO`: acknowledges, then goes to `ST_WR_DATA`.
- `ST_WR_DATA`: latches a data byte, then goes to `ST_ACK_WR`.
- `ST_ACK_WR`: acknowledges, then returns to `ST_WR_DATA`.
- `ST_RD_DATA`: shifts a byte out, then goes to `ST_RD_MACK`.
- `ST_RD_MACK`: samples the master's answer. An acknowledge returns to `ST_RD_DATA`; a not-acknowledge goes to `ST_IDLE`.

A STOP in any state goes to `ST_IDLE`. A START in any state goes to `ST_DEVSEL`.

Top module: `eep_slave_ctrl`

## Requirements
- R1: A device-select byte gets an acknowledge only when bits 7..4 equal 1010 and bits 3..1 equal `strap[2:1:0]` in that order. Otherwise the engine never pulls the line until the next START.
- R2: An acknowledge pulls the line low from the SCL fall after the eighth bit until the SCL fall after the ninth bit. At all other times in received bytes the line is left released.
- R3: The word address arrives as a high byte then a low byte. Bits 7..5 of the high byte are ignored.
- R4: Data written by a byte write and ended by STOP is found at its address by a later read.
- R5: Successive data bytes of one write advance only the low 5 address bits. A write running past the end of a 32-byte page wraps and overwrites the start of that same page.
- R6: After a STOP that ends a write holding at least one data byte, a device-select byte gets no acknowledge for `PROG_CYCLES` clocks. After that it is acknowledged again.
- R7: When `wp` is high at the STOP, the data bytes are still acknowledged, the array is left unchanged and no programming interval starts.
- R8: A random read returns the addressed byte MSB first. Each bit is on the line while SCL is high, as a released line for 1 and a pulled line for 0.
- R9: A read acknowledged by the master continues with the next address, and the next address after 0x1FFF is 0x0000.
- R10: After the master does not acknowledge a read byte, the engine releases the line and ignores further clocks until a START.
- R11: A read started without an address returns the byte after the last byte sent.
- R12: After reset the line is released and the engine is idle.
- R13: A STOP that follows only the address bytes starts no programming interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | One-cycle strobe: START or repeated START seen |
| stop_evt | input | 1 | One-cycle strobe: STOP seen |
| scl_rise | input | 1 | One-cycle strobe: SCL went high (sample point) |
| scl_fall | input | 1 | One-cycle strobe: SCL went low (drive point) |
| sda_in | input | 1 | Resolved level of the data line |
| strap | input | 3 | Device slot straps, compared with select bits 3..1 |
| wp | input | 1 | Write protect, high blocks programming |
| sda_pull | output | 1 | 1 = pull the data line low |

## Verification
The bench builds the engine with `PROG_CYCLES` = 400 and `ARRAY_AW` = 13. The array therefore spans all 8192 addresses, and the wrap from 0x1FFF to 0x0000 is visible with no aliasing. The short programming window lets the bench land a device-select byte inside the busy interval, then wait it out and see the acknowledge return, all in a few hundred clocks. Strobes are spaced several clocks apart, so array read latency stays hidden, as it does with a real bus front-end.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_ACK_DEV,
        ST_ADDR_HI,
        ST_ACK_HI,
        ST_ADDR_LO,
        ST_ACK_LO,
        ST_WR_DATA,
        ST_ACK_WR,
        ST_RD_DATA,
        ST_RD_MACK
    } eep_state_t;

    localparam logic [3:0] CTRL_CODE = 4'b1010;

endpackage

// File: rtl/eep_page_latch.sv
module eep_page_latch #(
    parameter int PAGE_BYTES = 32,
    localparam int IDX_W = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             clr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             any_valid
);

    logic [7:0]            data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (wr_en) data_q[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clr) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    assign rd_data   = data_q[rd_idx];
    assign rd_valid  = valid_q[rd_idx];
    assign any_valid = |valid_q;

endmodule

// File: rtl/eep_prog_engine.sv
module eep_prog_engine #(
    parameter int ADDR_W      = 13,
    parameter int PAGE_BYTES  = 32,
    parameter int PROG_CYCLES = 500000,
    localparam int IDX_W    = $clog2(PAGE_BYTES),
    localparam int BASE_W   = ADDR_W - IDX_W,
    localparam int PROG_LEN = (PROG_CYCLES > PAGE_BYTES) ? PROG_CYCLES : PAGE_BYTES,
    localparam int TW       = $clog2(PROG_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [BASE_W-1:0] page_base,
    output logic [IDX_W-1:0]  lat_idx,
    input  logic [7:0]        lat_data,
    input  logic              lat_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic              done
);

    logic              busy_q;
    logic [TW-1:0]     timer_q;
    logic [BASE_W-1:0] base_q;
    logic              copying;

    assign lat_idx   = timer_q[IDX_W-1:0];
    assign copying   = busy_q && (timer_q < TW'(PAGE_BYTES));
    assign mem_we    = copying && lat_valid;
    assign mem_addr  = {base_q, timer_q[IDX_W-1:0]};
    assign mem_wdata = lat_data;
    assign done      = busy_q && (timer_q == TW'(PROG_LEN - 1));
    assign busy      = busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            timer_q <= '0;
            base_q  <= '0;
        end else if (!busy_q) begin
            if (go) begin
                busy_q  <= 1'b1;
                timer_q <= '0;
                base_q  <= page_base;
            end
        end else if (done) begin
            busy_q  <= 1'b0;
            timer_q <= '0;
        end else begin
            timer_q <= timer_q + TW'(1);
        end
    end

    AST_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(timer_q) == TW'(PROG_LEN - 1))); // R6

endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [2**AW];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/eep_slave_ctrl.sv
module eep_slave_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int PAGE_BYTES  = 32,
    parameter int ARRAY_AW    = 11,
    parameter int PROG_CYCLES = 500000,
    localparam int IDX_W  = $clog2(PAGE_BYTES),
    localparam int BASE_W = ADDR_W - IDX_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_in,
    input  logic [2:0] strap,
    input  logic       wp,
    output logic       sda_pull
);

    eep_state_t state_q, state_d;

    logic [2:0]        cnt_q;
    logic [7:0]        rx_q;
    logic [7:0]        rx_next;
    logic [6:0]        tx_q;
    logic              phase_q;
    logic              mack_q;
    logic [ADDR_W-1:0] addr_q;
    logic              pull_q;

    logic              byte_done;
    logic              rx_state;
    logic              ack_state;
    logic              dev_ok;

    logic              prog_busy, prog_done, prog_go;
    logic              latch_we, latch_clr;
    logic [IDX_W-1:0]  lat_idx;
    logic [7:0]        lat_data;
    logic              lat_valid, lat_any;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        rd_data;

    assign rx_next   = {rx_q[6:0], sda_in};
    assign byte_done = scl_rise && (cnt_q == 3'd7);
    assign rx_state  = (state_q == ST_DEVSEL) || (state_q == ST_ADDR_HI) ||
                       (state_q == ST_ADDR_LO) || (state_q == ST_WR_DATA);
    assign ack_state = (state_q == ST_ACK_DEV) || (state_q == ST_ACK_HI) ||
                       (state_q == ST_ACK_LO) || (state_q == ST_ACK_WR) ||
                       (state_q == ST_RD_MACK);
    assign dev_ok    = (rx_q[7:4] == CTRL_CODE) && (rx_q[3:1] == strap) && !prog_busy;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        if (stop_evt) begin
            state_d = ST_IDLE;
        end else if (start_evt) begin
            state_d = ST_DEVSEL;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_DEVSEL:  if (byte_done) state_d = ST_ACK_DEV;
                ST_ACK_DEV: if (scl_fall) begin
                    if (!phase_q && !dev_ok) state_d = ST_IDLE;
                    else if (phase_q)        state_d = rx_q[0] ? ST_RD_DATA : ST_ADDR_HI;
                end
                ST_ADDR_HI: if (byte_done) state_d = ST_ACK_HI;
                ST_ACK_HI:  if (scl_fall && phase_q) state_d = ST_ADDR_LO;
                ST_ADDR_LO: if (byte_done) state_d = ST_ACK_LO;
                ST_ACK_LO:  if (scl_fall && phase_q) state_d = ST_WR_DATA;
                ST_WR_DATA: if (byte_done) state_d = ST_ACK_WR;
                ST_ACK_WR:  if (scl_fall && phase_q) state_d = ST_WR_DATA;
                ST_RD_DATA: if (byte_done) state_d = ST_RD_MACK;
                ST_RD_MACK: if (scl_fall && phase_q) state_d = mack_q ? ST_RD_DATA : ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- datapath and line driver ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            phase_q <= 1'b0;
            mack_q  <= 1'b0;
            addr_q  <= '0;
            pull_q  <= 1'b0;
        end else if (stop_evt || start_evt) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            pull_q  <= 1'b0;
        end else begin
            if (scl_rise && (rx_state || state_q == ST_RD_DATA))
                cnt_q <= cnt_q + 3'd1;
            if (scl_rise && rx_state)
                rx_q <= rx_next;

            if (byte_done) begin
                if (state_q == ST_ADDR_HI) addr_q[ADDR_W-1:8] <= rx_next[ADDR_W-9:0];
                if (state_q == ST_ADDR_LO) addr_q[7:0] <= rx_next;
                if (state_q == ST_WR_DATA) addr_q[IDX_W-1:0] <= addr_q[IDX_W-1:0] + IDX_W'(1);
                if (state_q == ST_RD_DATA) addr_q <= addr_q + ADDR_W'(1);
            end

            if (scl_fall && state_q == ST_RD_DATA) begin
                tx_q   <= {tx_q[5:0], 1'b0};
                pull_q <= ~tx_q[6];
            end

            if (scl_rise && state_q == ST_RD_MACK)
                mack_q <= ~sda_in;

            if (scl_fall && ack_state) begin
                phase_q <= ~phase_q;
                if (!phase_q) begin
                    pull_q <= (state_q != ST_RD_MACK) && ((state_q != ST_ACK_DEV) || dev_ok);
                end else if (state_d == ST_RD_DATA) begin
                    tx_q   <= rd_data[6:0];
                    pull_q <= ~rd_data[7];
                end else begin
                    pull_q <= 1'b0;
                end
            end
        end
    end

    assign sda_pull = pull_q;

    // ---------------- write path ----------------
    assign latch_we  = (state_q == ST_WR_DATA) && byte_done && !stop_evt && !start_evt;
    assign latch_clr = (start_evt && !prog_busy) || prog_done;
    assign prog_go   = stop_evt && ((state_q == ST_WR_DATA) || (state_q == ST_ACK_WR)) &&
                       lat_any && !wp && !prog_busy;

    eep_page_latch #(.PAGE_BYTES(PAGE_BYTES)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (latch_we),
        .wr_idx   (addr_q[IDX_W-1:0]),
        .wr_data  (rx_next),
        .clr      (latch_clr),
        .rd_idx   (lat_idx),
        .rd_data  (lat_data),
        .rd_valid (lat_valid),
        .any_valid(lat_any)
    );

    eep_prog_engine #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .PROG_CYCLES(PROG_CYCLES)
    ) u_prog (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (prog_go),
        .page_base(addr_q[ADDR_W-1:IDX_W]),
        .lat_idx  (lat_idx),
        .lat_data (lat_data),
        .lat_valid(lat_valid),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .busy     (prog_busy),
        .done     (prog_done)
    );

    eep_array #(.AW(ARRAY_AW)) u_array (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_addr[ARRAY_AW-1:0]),
        .wdata(mem_wdata),
        .raddr(addr_q[ARRAY_AW-1:0]),
        .rdata(rd_data)
    );

    // ---------------- assertions ----------------
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_pull); // R10

    AST_PULL_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> (ack_state || state_q == ST_RD_DATA)); // R2

    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK_DEV && prog_busy) |-> !sda_pull); // R6

    AST_WP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_busy) |-> !$past(wp)); // R7

    AST_PAGE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        latch_we |=> $stable(addr_q[ADDR_W-1:IDX_W])); // R5

    AST_RD_INCR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_DATA && byte_done) |=> (addr_q == ADDR_W'($past(addr_q) + ADDR_W'(1)))); // R9

endmodule

// File: tb/tb_eep_slave_ctrl.sv
module tb_eep_slave_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 400;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] SEL_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] SEL_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_evt = 1'b0, stop_evt = 1'b0, scl_rise = 1'b0, scl_fall = 1'b0;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_pull;
    logic sda_line;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    assign sda_line = m_sda & ~sda_pull;

    eep_slave_ctrl #(
        .ADDR_W(13), .PAGE_BYTES(32), .ARRAY_AW(13), .PROG_CYCLES(PROG)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_line),
        .strap(STRAP), .wp(wp), .sda_pull(sda_pull)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic strobe(input int which);
        @(posedge clk); #1;
        case (which)
            0: start_evt = 1'b1;
            1: stop_evt  = 1'b1;
            2: scl_rise  = 1'b1;
            default: scl_fall = 1'b1;
        endcase
        @(posedge clk); #1;
        start_evt = 1'b0; stop_evt = 1'b0; scl_rise = 1'b0; scl_fall = 1'b0;
    endtask

    task automatic clk_bit(input logic mb, output logic bus);
        strobe(3);
        cyc(3);
        m_sda = mb;
        cyc(2);
        strobe(2);
        cyc(3);
        bus = sda_line;
    endtask

    task automatic do_start();
        strobe(0);
        cyc(2);
    endtask

    task automatic do_restart();
        strobe(3); cyc(2); m_sda = 1'b1; cyc(2); strobe(2); cyc(2);
        strobe(0); cyc(2);
    endtask

    task automatic do_stop();
        strobe(3); cyc(2); m_sda = 1'b0; cyc(2); strobe(2); cyc(2);
        strobe(1); m_sda = 1'b1; cyc(2);
    endtask

    // returns ack (1 = acknowledged) and whether the line ever differed from the master
    task automatic send_byte(input logic [7:0] b, output logic ack, output logic clash);
        logic bus;
        clash = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(b[i], bus);
            if (bus != b[i]) clash = 1'b1;
        end
        clk_bit(1'b1, bus);
        ack = ~bus;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        logic bus;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, bus);
            b[i] = bus;
        end
        clk_bit(~m_ack, bus);
    endtask

    task automatic write_seq(input logic [7:0] hi, input logic [7:0] lo,
                             input logic [31:0] data, input int n, input string req);
        logic a, c;
        do_start();
        send_byte(SEL_W, a, c); chk(a, req, a, 1);
        send_byte(hi, a, c);    chk(a, req, a, 1);
        send_byte(lo, a, c);    chk(a, req, a, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(data[31-8*k -: 8], a, c);
            chk(a && !c, req, {a, c}, 2);
        end
        do_stop();
    endtask

    task automatic random_read(input logic [7:0] hi, input logic [7:0] lo, output logic [7:0] b);
        logic a, c;
        do_start();
        send_byte(SEL_W, a, c);
        send_byte(hi, a, c);
        send_byte(lo, a, c);
        do_restart();
        send_byte(SEL_R, a, c);
        chk(a, "R8 read select ack", a, 1);
        recv_byte(1'b0, b);
        do_stop();
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(sda_pull == 1'b0, "R12 line released after reset", sda_pull, 0);
    endtask

    task automatic t_select_mismatch();
        logic a, c;
        do_start();
        send_byte({4'b1010, 3'b001, 1'b0}, a, c);
        chk(!a, "R1 strap mismatch not acked", a, 0);
        send_byte(8'h00, a, c);
        chk(!a && !c, "R1 silent after refusal", {a, c}, 0);
        do_stop();
        do_start();
        send_byte({4'b1011, STRAP, 1'b0}, a, c);
        chk(!a, "R1 wrong control code not acked", a, 0);
        do_stop();
    endtask

    task automatic t_byte_write();
        logic a, c;
        logic [7:0] b;
        write_seq(8'hE1, 8'h23, {8'hA5, 24'h0}, 1, "R2 R3 write acks and release");
        do_start();
        send_byte(SEL_W, a, c);
        chk(!a, "R6 no ack while programming", a, 0);
        do_stop();
        cyc(PROG + 20);
        do_start();
        send_byte(SEL_W, a, c);
        chk(a, "R6 ack after programming window", a, 1);
        do_stop();
        random_read(8'h01, 8'h23, b);
        chk(b == 8'hA5, "R4 R3 byte readback", b, 8'hA5);
    endtask

    task automatic t_page_wrap();
        logic [7:0] b;
        write_seq(8'h00, 8'h5E, 32'h5E5F4041, 4, "R5 page bytes acked");
        cyc(PROG + 20);
        random_read(8'h00, 8'h5E, b); chk(b == 8'h5E, "R5 byte at 0x5E", b, 8'h5E);
        random_read(8'h00, 8'h5F, b); chk(b == 8'h5F, "R5 byte at 0x5F", b, 8'h5F);
        random_read(8'h00, 8'h40, b); chk(b == 8'h40, "R5 wrapped byte at 0x40", b, 8'h40);
        random_read(8'h00, 8'h41, b); chk(b == 8'h41, "R5 wrapped byte at 0x41", b, 8'h41);
    endtask

    task automatic t_write_protect();
        logic a, c;
        logic [7:0] b;
        wp = 1'b1;
        write_seq(8'h01, 8'h23, {8'h3C, 24'h0}, 1, "R7 acks under protect");
        do_start();
        send_byte(SEL_W, a, c);
        chk(a, "R7 no programming window", a, 1);
        do_stop();
        wp = 1'b0;
        random_read(8'h01, 8'h23, b);
        chk(b == 8'hA5, "R7 array unchanged", b, 8'hA5);
    endtask

    task automatic t_addr_only();
        logic a, c;
        do_start();
        send_byte(SEL_W, a, c);
        send_byte(8'h00, a, c);
        send_byte(8'h10, a, c);
        do_stop();
        do_start();
        send_byte(SEL_W, a, c);
        chk(a, "R13 address-only write starts no window", a, 1);
        do_stop();
    endtask

    task automatic t_seq_wrap();
        logic a, c, bus;
        logic [7:0] b;
        write_seq(8'h1F, 8'hFF, {8'h77, 24'h0}, 1, "R9 setup top byte");
        cyc(PROG + 20);
        write_seq(8'h00, 8'h00, {16'h1122, 16'h0}, 2, "R9 setup bottom bytes");
        cyc(PROG + 20);
        do_start();
        send_byte(SEL_W, a, c);
        send_byte(8'h1F, a, c);
        send_byte(8'hFF, a, c);
        do_restart();
        send_byte(SEL_R, a, c);
        recv_byte(1'b1, b);
        chk(b == 8'h77, "R8 read at 0x1FFF", b, 8'h77);
        recv_byte(1'b0, b);
        chk(b == 8'h11, "R9 wrap to 0x0000", b, 8'h11);
        clk_bit(1'b1, bus);
        chk(bus == 1'b1 && sda_pull == 1'b0, "R10 released after master nack", bus, 1);
        clk_bit(1'b0, bus);
        clk_bit(1'b1, bus);
        chk(bus == 1'b1, "R10 further clocks ignored", bus, 1);
        do_stop();
        do_start();
        send_byte(SEL_R, a, c);
        recv_byte(1'b0, b);
        do_stop();
        chk(b == 8'h22, "R11 current-address read", b, 8'h22);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_select_mismatch();
        t_byte_write();
        t_page_wrap();
        t_write_protect();
        t_addr_only();
        t_seq_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule